// File: doc/BRIEF.md
# Shift-Register Audio Frame Sequencer

This block produces the slow timing strobes for a sound unit: a quarter-frame pulse, a half-frame pulse and a frame interrupt flag. It does not use a binary divider. A 15-bit linear feedback shift register counts sequencer ticks, and a step decoder compares the register against the values it takes after a set number of ticks. Each CPU cycle has two halves, marked by a phase input. Register writes and status acknowledges are taken in the bus half. The shift register and every output register change only in the sequencer half, and only on every second CPU cycle.

A write to the control register picks either a 4-step or a 5-step sequence and can mask the interrupt. The write also restarts the sequence. The restart does not happen at once: it waits for a particular parity of sequencer cycle, so it lands two or three CPU cycles after the write. In 5-step mode the restart also fires both pulses. Step positions are parameters given in sequencer ticks from the all-ones load. Their defaults give the usual uneven gaps between steps.

Top module: `frame_sequencer`

## Requirements
- R1: After reset, all three outputs are low, the mode is 4-step, the interrupt is not masked, and the shift register holds all ones. The first sequencer half after reset is an even cycle.
- R2: The register advances only in sequencer halves (bus_phase_i low) of odd CPU cycles. With no writes after reset, step k fires on CPU cycle 2*STEPk_TICKS+1, counting the first cycle after reset as cycle 0. A pulse lasts for one CPU cycle, which is two clock edges.
- R3: The quarter-frame pulse fires on steps 1, 2, 3 and on the final step. The half-frame pulse fires only on step 2 and on the final step. The half pulse is never high without the quarter pulse.
- R4: In 4-step mode, step 4 is the final step. It reloads all ones, so the pattern repeats every 2*(STEP4_TICKS+1) CPU cycles.
- R5: In 5-step mode, step 4 gives no pulse, no reload and no interrupt. Step 5 is the final step and reloads all ones. The interrupt flag is never set in this mode.
- R6: Data bit 7 of a write selects the mode (1 = 5-step, 0 = 4-step). Every write reloads the register. If bit 7 is 1, the reload also fires both pulses. If bit 7 is 0, the reload fires no pulse.
- R7: A write's reload happens on the first odd sequencer half that follows the first even sequencer half after the write cycle. This is CPU cycle w+2 for an odd write cycle w and w+3 for an even one. On that tick the decoded step pulses are suppressed.
- R8: In 4-step mode with the interrupt not masked, step 4 sets the interrupt flag, and irq_o follows it. The flag stays set until a status acknowledge or a masking write. The flag never rises on a bus-half edge.
- R9: Data bit 6 of a write (value 0x40) masks the interrupt and clears the flag in the write's own cycle. A write with bit 6 clear leaves the flag unchanged.
- R10: A write strobe or acknowledge asserted during a sequencer half is ignored. Outputs hold across every bus-half edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock, one edge per CPU half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase_i | input | 1 | High in the bus half of a CPU cycle, low in the sequencer half |
| wr_en_i | input | 1 | Control register write strobe, taken in the bus half |
| wr_data_i | input | 8 | Write data: bit 7 selects the mode, bit 6 masks the interrupt |
| stat_ack_i | input | 1 | Status-read acknowledge, clears the interrupt flag |
| qtr_pulse_o | output | 1 | Quarter-frame pulse, one CPU cycle long |
| half_pulse_o | output | 1 | Half-frame pulse, one CPU cycle long |
| irq_o | output | 1 | Frame interrupt request (level) |

## Verification
The assertions assume that bus_phase_i alternates on every clock edge, so that bus edges and sequencer edges follow one another and never coincide. They also assume that a write or acknowledge seen in a bus half is the only way to clear the flag. The bench drives the phase as a strict alternation, starting with a bus half after reset. It asserts the write and acknowledge strobes in the bus half, except for one deliberate late write in a sequencer half that checks that such a write is ignored. Small step positions are used, so full sequences in both modes run in a few hundred cycles.

// File: rtl/frmseq_pkg.sv
// Package for the frame sequencer: register geometry, field positions,
// the write-alignment state type and constant functions that give the
// shift-register state reached after a number of ticks.
package frmseq_pkg;

    localparam int LFSR_W    = 15;
    localparam int TAP_LO    = 13;
    localparam int TAP_HI    = 14;
    localparam int NUM_STEPS = 5;
    localparam int DATA_W    = 8;
    localparam int MODE_BIT  = 7;
    localparam int MASK_BIT  = 6;

    // Step roles, bit k = step k+1 (before the mode filter)
    localparam logic [NUM_STEPS-1:0] QTR_ROLE  = 5'b11111;
    localparam logic [NUM_STEPS-1:0] HALF_ROLE = 5'b11010;
    localparam logic [NUM_STEPS-1:0] LAST_ROLE = 5'b11000;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [LFSR_W-1:0][LFSR_W-1:0] lfsr_mat_t;

    typedef enum logic [1:0] {
        ALN_IDLE,
        ALN_ARMED,
        ALN_SEEK_EVEN,
        ALN_SEEK_ODD
    } align_state_t;

    // One shift step; an all-zero register is kicked out with a one.
    function automatic lfsr_t lfsr_next(input lfsr_t s);
        lfsr_t r;
        if (s == '0) begin
            r = lfsr_t'(1);
        end else begin
            r = {s[LFSR_W-2:0], s[TAP_LO] ^ s[TAP_HI]};
        end
        return r;
    endfunction

    // Transition matrix over GF(2): row i is the mask of bits feeding bit i.
    function automatic lfsr_mat_t step_matrix();
        lfsr_mat_t m;
        m = '0;
        m[0][TAP_LO] = 1'b1;
        m[0][TAP_HI] = 1'b1;
        for (int i = 1; i < LFSR_W; i++) begin
            m[i][i-1] = 1'b1;
        end
        return m;
    endfunction

    // Apply a matrix to a state vector.
    function automatic lfsr_t mat_apply(input lfsr_mat_t m, input lfsr_t v);
        lfsr_t r;
        for (int i = 0; i < LFSR_W; i++) begin
            r[i] = ^(m[i] & v);
        end
        return r;
    endfunction

    // Product a*b (b applied first).
    function automatic lfsr_mat_t mat_mult(input lfsr_mat_t a, input lfsr_mat_t b);
        lfsr_mat_t c;
        c = '0;
        for (int i = 0; i < LFSR_W; i++) begin
            for (int j = 0; j < LFSR_W; j++) begin
                if (a[i][j]) begin
                    c[i] = c[i] ^ b[j];
                end
            end
        end
        return c;
    endfunction

    // State after n ticks from all ones, by square-and-multiply.
    function automatic lfsr_t state_after(input int unsigned n);
        lfsr_t     v;
        lfsr_mat_t p;
        v = '1;
        p = step_matrix();
        for (int k = 0; k < 32; k++) begin
            if (n[k]) begin
                v = mat_apply(p, v);
            end
            p = mat_mult(p, p);
        end
        return v;
    endfunction

endpackage

// File: rtl/frmseq_lfsr.sv
// Sequencer shift register.
// Holds the 15-bit state; a load returns it to all ones, otherwise it
// shifts when advanced. Assumes load and advance come from sequencer
// halves only.
module frmseq_lfsr
    import frmseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  logic  load_i,
    output lfsr_t state_o
);

    lfsr_t state_q;

    // State register: reset/load to all ones, else shift on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (load_i) begin
            state_q <= '1;
        end else if (adv_i) begin
            state_q <= lfsr_next(state_q);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/frmseq_decode.sv
// Step decoder.
// Compares the register with the state reached after each step's tick
// count and maps the hits to pulse, reload and interrupt requests.
// Assumes the step tick counts are increasing and below the register period.
module frmseq_decode
    import frmseq_pkg::*;
#(
    parameter int unsigned STEP1_TICKS = 3728,
    parameter int unsigned STEP2_TICKS = 7456,
    parameter int unsigned STEP3_TICKS = 11185,
    parameter int unsigned STEP4_TICKS = 14914,
    parameter int unsigned STEP5_TICKS = 18640
) (
    input  lfsr_t state_i,
    input  logic  five_i,
    output logic  qtr_o,
    output logic  half_o,
    output logic  last_o,
    output logic  irq_o
);

    localparam int unsigned STEP_AT [NUM_STEPS] = '{
        STEP1_TICKS, STEP2_TICKS, STEP3_TICKS, STEP4_TICKS, STEP5_TICKS
    };

    logic [NUM_STEPS-1:0] hit;
    logic [NUM_STEPS-1:0] live;

    // One comparator per step against its precomputed state
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        localparam lfsr_t MATCH = state_after(STEP_AT[k]);
        assign hit[k] = (state_i == MATCH);
    end

    // Mode filter: step 4 exists only in the 4-step sequence
    always_comb begin
        live    = hit;
        live[3] = hit[3] & ~five_i;
    end

    // Map live steps to the roles they carry
    always_comb begin
        qtr_o  = |(live & QTR_ROLE);
        half_o = |(live & HALF_ROLE);
        last_o = |(live & LAST_ROLE);
        irq_o  = live[3];
    end

endmodule

// File: rtl/frmseq_ctrl.sv
// Control register, cycle parity and write alignment.
// Captures mode and mask in the bus half, tracks odd/even CPU cycles in the
// sequencer half, and times a write's reload to the odd sequencer half that
// follows the first even one after the write. Assumes bus_phase_i alternates.
module frmseq_ctrl
    import frmseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              five_o,
    output logic              mask_o,
    output logic              odd_o,
    output logic              apply_o,
    output logic              clr_o
);

    logic         bus_wr;
    logic         seq_half;
    logic         odd_q;
    logic         five_q;
    logic         mask_q;
    align_state_t aln_q;
    align_state_t aln_d;

    assign bus_wr   = bus_phase_i & wr_en_i;
    assign seq_half = ~bus_phase_i;

    // Cycle parity: toggles once per CPU cycle in the sequencer half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else if (seq_half) begin
            odd_q <= ~odd_q;
        end
    end

    // Control fields captured on a bus-half write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            five_q <= 1'b0;
            mask_q <= 1'b0;
        end else if (bus_wr) begin
            five_q <= wr_data_i[MODE_BIT];
            mask_q <= wr_data_i[MASK_BIT];
        end
    end

    // Alignment next state: write arms, then even, then odd sequencer half
    always_comb begin
        aln_d = aln_q;
        if (bus_wr) begin
            aln_d = ALN_ARMED;
        end else if (seq_half) begin
            unique case (aln_q)
                ALN_ARMED:     aln_d = ALN_SEEK_EVEN;
                ALN_SEEK_EVEN: aln_d = odd_q ? ALN_SEEK_EVEN : ALN_SEEK_ODD;
                ALN_SEEK_ODD:  aln_d = odd_q ? ALN_IDLE : ALN_SEEK_ODD;
                default:       aln_d = ALN_IDLE;
            endcase
        end
    end

    // Alignment state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aln_q <= ALN_IDLE;
        end else begin
            aln_q <= aln_d;
        end
    end

    assign five_o  = five_q;
    assign mask_o  = mask_q;
    assign odd_o   = odd_q;
    assign apply_o = seq_half & odd_q & (aln_q == ALN_SEEK_ODD);
    assign clr_o   = bus_wr & wr_data_i[MASK_BIT];

endmodule

// File: rtl/frmseq_irq.sv
// Frame interrupt flag.
// Set by a sequencer-half request, cleared by a bus-half request.
// Assumes the two requests come from opposite halves.
module frmseq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Flag register: clear wins, then set, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/frame_sequencer.sv
// Audio frame sequencer top.
// Ties the shift register, step decoder, control/alignment and interrupt
// flag together and registers the two pulses in the sequencer half.
// Assumes clk has one edge per CPU half-cycle and bus_phase_i alternates.
module frame_sequencer
    import frmseq_pkg::*;
#(
    parameter int unsigned STEP1_TICKS = 3728,
    parameter int unsigned STEP2_TICKS = 7456,
    parameter int unsigned STEP3_TICKS = 11185,
    parameter int unsigned STEP4_TICKS = 14914,
    parameter int unsigned STEP5_TICKS = 18640
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              stat_ack_i,
    output logic              qtr_pulse_o,
    output logic              half_pulse_o,
    output logic              irq_o
);

    lfsr_t state;
    logic  ctl_five;
    logic  ctl_inhibit;
    logic  ctl_odd;
    logic  ctl_apply;
    logic  ctl_clr;
    logic  dec_qtr;
    logic  dec_half;
    logic  dec_last;
    logic  dec_irq;
    logic  tick;
    logic  lfsr_load;
    logic  irq_set;
    logic  irq_clr;
    logic  qtr_d;
    logic  half_d;
    logic  qtr_q;
    logic  half_q;
    logic  unused_data;

    assign unused_data = ^wr_data_i[MASK_BIT-1:0];

    frmseq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_phase_i (bus_phase_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .five_o      (ctl_five),
        .mask_o      (ctl_inhibit),
        .odd_o       (ctl_odd),
        .apply_o     (ctl_apply),
        .clr_o       (ctl_clr)
    );

    frmseq_decode #(
        .STEP1_TICKS (STEP1_TICKS),
        .STEP2_TICKS (STEP2_TICKS),
        .STEP3_TICKS (STEP3_TICKS),
        .STEP4_TICKS (STEP4_TICKS),
        .STEP5_TICKS (STEP5_TICKS)
    ) u_decode (
        .state_i (state),
        .five_i  (ctl_five),
        .qtr_o   (dec_qtr),
        .half_o  (dec_half),
        .last_o  (dec_last),
        .irq_o   (dec_irq)
    );

    // Sequencer tick: odd CPU cycle, sequencer half
    assign tick      = ~bus_phase_i & ctl_odd;
    assign lfsr_load = ctl_apply | (tick & dec_last);

    frmseq_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (tick),
        .load_i  (lfsr_load),
        .state_o (state)
    );

    assign irq_set = tick & ~ctl_apply & dec_irq & ~ctl_inhibit;
    assign irq_clr = (bus_phase_i & stat_ack_i) | ctl_clr;

    frmseq_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flag_o (irq_o)
    );

    // Pulse request: an aligned write overrides the decoded step
    always_comb begin
        if (ctl_apply) begin
            qtr_d  = ctl_five;
            half_d = ctl_five;
        end else if (tick) begin
            qtr_d  = dec_qtr;
            half_d = dec_half;
        end else begin
            qtr_d  = 1'b0;
            half_d = 1'b0;
        end
    end

    // Pulse registers: update only in sequencer halves, so each lasts a CPU cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (!bus_phase_i) begin
            qtr_q  <= qtr_d;
            half_q <= half_d;
        end
    end

    assign qtr_pulse_o  = qtr_q;
    assign half_pulse_o = half_q;

endmodule

// File: rtl/frame_sequencer_chk.sv
// Property checker for frame_sequencer, attached with bind below.
module frame_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_phase_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       stat_ack_i,
    input logic       qtr_pulse_o,
    input logic       half_pulse_o,
    input logic       irq_o,
    input logic       inhibit_q
);

    assert_hold_on_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase_i |=> ($stable(qtr_pulse_o) && $stable(half_pulse_o)));

    assert_half_implies_qtr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse_o |-> qtr_pulse_o);

    assert_no_rise_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase_i |=> !$rose(irq_o));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase_i && stat_ack_i) |=> !irq_o);

    assert_mask_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase_i && wr_en_i && wr_data_i[6]) |=> !irq_o);

    assert_masked_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_q |=> !$rose(irq_o));

    assert_pulse_two_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qtr_pulse_o) |=> qtr_pulse_o);

endmodule

bind frame_sequencer frame_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_phase_i  (bus_phase_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .stat_ack_i   (stat_ack_i),
    .qtr_pulse_o  (qtr_pulse_o),
    .half_pulse_o (half_pulse_o),
    .irq_o        (irq_o),
    .inhibit_q    (ctl_inhibit)
);

// File: tb/frame_sequencer_test.sv
module frame_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int S1 = 4;
    localparam int S2 = 9;
    localparam int S3 = 15;
    localparam int S4 = 21;
    localparam int S5 = 26;

    // {cycle[7:0], qtr, half, irq} for a 4-step run from reset
    localparam int NVEC = 11;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'd8,  3'b000}, {8'd9,  3'b100}, {8'd10, 3'b000},
        {8'd19, 3'b110}, {8'd31, 3'b100}, {8'd42, 3'b000},
        {8'd43, 3'b111}, {8'd44, 3'b001}, {8'd53, 3'b101},
        {8'd63, 3'b111}, {8'd87, 3'b111}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_phase = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_ack = 1'b0;
    logic       qtr, half, irq;

    int nchecks = 0;
    int nerrors = 0;
    int cyc = 0;

    frame_sequencer #(
        .STEP1_TICKS (S1), .STEP2_TICKS (S2), .STEP3_TICKS (S3),
        .STEP4_TICKS (S4), .STEP5_TICKS (S5)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bus_phase_i (bus_phase),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .stat_ack_i (stat_ack),
        .qtr_pulse_o (qtr), .half_pulse_o (half), .irq_o (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic eq, input logic eh, input logic ei);
        nchecks++;
        if (qtr !== eq || half !== eh || irq !== ei) begin
            nerrors++;
            $display("FAIL %s cycle %0d: got q=%b h=%b irq=%b expected q=%b h=%b irq=%b",
                     tag, cyc - 1, qtr, half, irq, eq, eh, ei);
        end
    endtask

    // One CPU cycle: bus half edge then sequencer half edge
    task automatic cpu_cycle(input logic wr, input logic [7:0] d, input logic ack, input logic late);
        bus_phase = 1'b1;
        wr_en     = wr & ~late;
        wr_data   = d;
        stat_ack  = ack;
        @(posedge clk); #1;
        bus_phase = 1'b0;
        wr_en     = wr & late;
        stat_ack  = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0;
        cyc++;
    endtask

    task automatic run_to(input int c);
        while (cyc <= c) cpu_cycle(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic write_at(input int c, input logic [7:0] d, input logic late);
        run_to(c - 1);
        cpu_cycle(1'b1, d, 1'b0, late);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_phase = 1'b1;
        wr_en = 1'b0;
        stat_ack = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nerrors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end

    initial begin
        // Vector walk: 4-step sequence from reset (R2, R3, R4, R8)
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            run_to(int'(VEC[i][10:3]));
            check("R2_R3_R4_R8 vector", VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset state
        do_reset();
        check("R1 reset", 1'b0, 1'b0, 1'b0);
        run_to(0);
        check("R1 first cycle", 1'b0, 1'b0, 1'b0);

        // R6/R7/R5: 5-step write on even cycle 2, reload lands on cycle 5
        do_reset();
        write_at(2, 8'h80, 1'b0);
        run_to(4);  check("R7 no early reload", 1'b0, 1'b0, 1'b0);
        run_to(5);  check("R6 forced pulses", 1'b1, 1'b1, 1'b0);
        run_to(9);  check("R7 old step1 gone", 1'b0, 1'b0, 1'b0);
        run_to(15); check("R7 step1 after reload", 1'b1, 1'b0, 1'b0);
        run_to(25); check("R5 step2", 1'b1, 1'b1, 1'b0);
        run_to(49); check("R5 step4 skipped", 1'b0, 1'b0, 1'b0);
        run_to(59); check("R5 step5 final", 1'b1, 1'b1, 1'b0);
        run_to(69); check("R5 reload at step5", 1'b1, 1'b0, 1'b0);

        // R7: write on odd cycle 3, reload on cycle 5
        do_reset();
        write_at(3, 8'h80, 1'b0);
        run_to(4);  check("R7 odd write wait", 1'b0, 1'b0, 1'b0);
        run_to(5);  check("R7 odd write +2", 1'b1, 1'b1, 1'b0);

        // R6: 4-step write reloads without pulses
        do_reset();
        write_at(3, 8'h00, 1'b0);
        run_to(5);  check("R6 no pulse 4-step", 1'b0, 1'b0, 1'b0);
        run_to(9);  check("R6 reload moved step1", 1'b0, 1'b0, 1'b0);
        run_to(15); check("R6 step1 after reload", 1'b1, 1'b0, 1'b0);

        // R10: write in the sequencer half is ignored
        do_reset();
        write_at(2, 8'h80, 1'b1);
        run_to(5);  check("R10 late write no pulse", 1'b0, 1'b0, 1'b0);
        run_to(9);  check("R10 step1 unchanged", 1'b1, 1'b0, 1'b0);
        run_to(43); check("R10 still 4-step", 1'b1, 1'b1, 1'b1);

        // R9: masking write, then step4 sets no flag
        do_reset();
        write_at(1, 8'h40, 1'b0);
        run_to(47); check("R9 masked step4", 1'b1, 1'b1, 1'b0);

        // R8: acknowledge clears, flag sets again next period
        do_reset();
        run_to(44); check("R8 flag set", 1'b0, 1'b0, 1'b1);
        cpu_cycle(1'b0, 8'h00, 1'b1, 1'b0);
        check("R8 ack clears", 1'b0, 1'b0, 1'b0);
        run_to(46); check("R8 stays clear", 1'b0, 1'b0, 1'b0);
        run_to(87); check("R8 set again", 1'b1, 1'b1, 1'b1);

        // R9: unmasked write keeps flag, masking write clears it
        write_at(88, 8'h00, 1'b0);
        check("R9 plain write keeps flag", 1'b0, 1'b0, 1'b1);
        write_at(89, 8'h40, 1'b0);
        check("R9 mask write clears", 1'b0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
        $finish;
    end

endmodule